// File: doc/BRIEF.md
# Mixed-Aspect Dual-Port Block Memory

This block is a synchronous memory with two fully independent ports. It holds 16,384 data cells and 2,048 parity cells. Each port has its own clock, synchronous active-low reset, enable, write enable, address, data and parity inputs, and registered data and parity outputs. A parameter sets the width of each port separately. Both ports map onto the same physical cells. A word written through one port can therefore be read back through the other port at a different width.

The port width decides how the address is split. A port of data width W covers W consecutive data cells per address. Widths of 8, 16 and 32 also carry 1, 2 or 4 parity cells per address, taken from the parity array. Initial data contents come from 64 row parameters of 256 bits each. The parity array starts cleared. If both ports write overlapping cells in the same cycle, the result is undefined, and the user must prevent it.

Top module: `dual_aspect_ram`

## Requirements
- R1: Each port's data width is 1, 2, 4, 8, 16 or 32, and its address has 14 - log2(width) bits. Every address in that range, up to the last one, reaches the array.
- R2: At data width W, address A reads and writes data cells A*W to A*W+W-1, with cell A*W on data bit 0. A write at one width is read back correctly at any other width.
- R3: At widths 8, 16 and 32 a port carries P = W/8 parity bits. Address A covers parity cells A*P to A*P+P-1, with the lowest cell on parity bit 0.
- R4: At widths 1, 2 and 4 the parity output stays 0, and the parity input changes no parity cell.
- R5: Row parameter k (0 to 63) gives the start value of data cells k*256 to k*256+255, with row bit 0 in cell k*256. For example, row 31 fills cells 7936 to 8191.
- R6: Rows left at their default value, and all parity cells, start at zero.
- R7: Reads are synchronous. The data and parity outputs change only at the clock edge where enable is high, and they show the cells addressed in that cycle.
- R8: While enable is low, the outputs hold their value and nothing is written, whatever the write enable, address and data inputs are.
- R9: On an enabled write, the port's outputs show the data and parity just written (write-first). Cells outside the addressed word keep their values.
- R10: While a port's reset is low, that port's data and parity outputs go to zero at each clock edge, even with enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of port A |
| rstn_a | input | 1 | Synchronous active-low reset of port A outputs |
| en_a | input | 1 | Port A access enable |
| we_a | input | 1 | Port A write enable (used when enabled) |
| addr_a | input | 14-log2(DATA_W_A) | Port A word address |
| din_a | input | DATA_W_A | Port A write data |
| pin_a | input | max(1, DATA_W_A/8) | Port A write parity (ignored below width 8) |
| dout_a | output | DATA_W_A | Port A registered read data |
| pout_a | output | max(1, DATA_W_A/8) | Port A registered parity (0 below width 8) |
| clk_b | input | 1 | Clock of port B |
| rstn_b | input | 1 | Synchronous active-low reset of port B outputs |
| en_b | input | 1 | Port B access enable |
| we_b | input | 1 | Port B write enable (used when enabled) |
| addr_b | input | 14-log2(DATA_W_B) | Port B word address |
| din_b | input | DATA_W_B | Port B write data |
| pin_b | input | max(1, DATA_W_B/8) | Port B write parity (ignored below width 8) |
| dout_b | output | DATA_W_B | Port B registered read data |
| pout_b | output | max(1, DATA_W_B/8) | Port B registered parity (0 below width 8) |

## Verification
Two configurations are tested: bytes against 32-bit words with parity on both ports, and 2-bit cells against 16-bit words. Directed bytes written narrow and read wide, and the reverse, show whether the lane order and parity order are right. Reads at the first, 31st and last rows show whether the row initialization is placed correctly. Random mixed accesses concentrated on a small region show whether a narrow write leaves its neighbours intact. Idle cycles that drive write enable with new data show whether the enable truly gates writes and holds the outputs.

// File: rtl/dpm_pkg.sv
// Package dpm_pkg
// Geometry of the shared cell array and width helpers used by every module
// of the dual-aspect memory. Assumes 32 data cells and 4 parity cells per
// physical storage word.
package dpm_pkg;

    localparam int DATA_CELLS  = 16384;
    localparam int PAR_CELLS   = 2048;
    localparam int ROW_W       = 256;
    localparam int ROWS        = DATA_CELLS / ROW_W;
    localparam int WORD_W      = 32;
    localparam int WORDS       = DATA_CELLS / WORD_W;
    localparam int PWORD_W     = PAR_CELLS / WORDS;
    localparam int WORDS_PER_ROW = ROW_W / WORD_W;
    localparam int WORD_IDX_W  = $clog2(WORDS);
    localparam int BIT_IDX_W   = $clog2(DATA_CELLS);
    localparam int OFF_W       = $clog2(WORD_W);
    localparam int POFF_W      = $clog2(PWORD_W);

    typedef logic [WORD_W-1:0]     word_t;
    typedef logic [PWORD_W-1:0]    pword_t;
    typedef logic [WORD_IDX_W-1:0] widx_t;
    typedef logic [OFF_W-1:0]      off_t;
    typedef logic [POFF_W-1:0]     poff_t;

    // Number of parity cells a port of the given data width reaches.
    function automatic int par_bits(input int w);
        return (w >= 8) ? (w / 8) : 0;
    endfunction

    // Physical width of the parity pins (at least one bit).
    function automatic int par_port_w(input int w);
        return (par_bits(w) > 0) ? par_bits(w) : 1;
    endfunction

    // True for the data widths the memory supports.
    function automatic bit width_ok(input int w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16) || (w == 32);
    endfunction

endpackage

// File: rtl/dpm_port.sv
// Module dpm_port
// One access port of the dual-aspect memory. Turns the port address into a
// storage word index plus data and parity lane offsets, raises the write
// strobe, and registers the read (or write-first) data and parity.
// Assumes the merged storage word for its own word index arrives
// combinationally on rd_data / rd_par within the same cycle.
module dpm_port
    import dpm_pkg::*;
#(
    parameter int DW = 8,
    localparam int PW  = par_bits(DW),
    localparam int PPW = par_port_w(DW),
    localparam int AW  = BIT_IDX_W - $clog2(DW)
) (
    input  logic           clk,
    input  logic           rstn,
    input  logic           en,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  din,
    input  logic [PPW-1:0] pin,
    input  word_t          rd_data,
    input  pword_t         rd_par,
    output widx_t          word_idx,
    output off_t           bit_off,
    output poff_t          par_off,
    output logic           wr_go,
    output logic [DW-1:0]  dout,
    output logic [PPW-1:0] pout
);

    logic [BIT_IDX_W-1:0] bit_pos;
    logic [DW-1:0]        rd_slice;

    // First data cell of the addressed word, split into word and lane.
    assign bit_pos  = BIT_IDX_W'(addr) << $clog2(DW);
    assign word_idx = bit_pos[BIT_IDX_W-1:OFF_W];
    assign bit_off  = bit_pos[OFF_W-1:0];
    assign wr_go    = en & we;
    assign rd_slice = rd_data[bit_off +: DW];

    // Data output register: reset, write-first or read, else hold.
    always_ff @(posedge clk) begin
        if (!rstn) begin
            dout <= '0;
        end else if (en) begin
            dout <= we ? din : rd_slice;
        end
    end

    generate
        if (PW > 0) begin : g_par
            logic [POFF_W-1:0] addr_lo;
            logic [PW-1:0]     rd_pslice;

            // Parity lane offset: address times parity cells per word.
            assign addr_lo   = POFF_W'(addr);
            assign par_off   = addr_lo << $clog2(PW);
            assign rd_pslice = rd_par[par_off +: PW];

            // Parity output register, same policy as the data register.
            always_ff @(posedge clk) begin
                if (!rstn) begin
                    pout <= '0;
                end else if (en) begin
                    pout <= we ? pin : rd_pslice;
                end
            end

            // R9: parity written is what the port shows next cycle.
            assert_par_first_R9: assert property (@(posedge clk) disable iff (!rstn)
                (en && we) |=> (pout == $past(pin)));

            // R8: parity output holds while the port is idle.
            assert_par_hold_R8: assert property (@(posedge clk) disable iff (!rstn)
                (!en) |=> $stable(pout));
        end else begin : g_nopar
            logic unused_par;

            // No parity at this width: inputs are dropped, output is zero.
            assign unused_par = ^{pin, rd_par};
            assign par_off    = '0;
            assign pout       = '0;
        end
    endgenerate

    // R9: data written is what the port shows next cycle.
    assert_wr_first_R9: assert property (@(posedge clk) disable iff (!rstn)
        (en && we) |=> (dout == $past(din)));

    // R8: data output holds while the port is idle.
    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rstn)
        (!en) |=> $stable(dout));

endmodule

// File: rtl/dpm_bank.sv
// Module dpm_bank
// One of two storage banks. Only its own port writes it. The logical cell
// value is this bank XOR the other bank, so a write stores the new data XOR
// the other bank's current contents of the same lane. Assumes the other
// bank's word at this port's address arrives on peer_at_mine.
module dpm_bank
    import dpm_pkg::*;
#(
    parameter int DW = 8,
    parameter bit LOAD_ROWS = 1'b0,
    parameter logic [ROW_W-1:0] INIT_ROWS [ROWS] = '{default: '0},
    localparam int PW  = par_bits(DW),
    localparam int PPW = par_port_w(DW)
) (
    input  logic           clk,
    input  logic           wr_go,
    input  widx_t          wr_word,
    input  off_t           wr_off,
    input  poff_t          wr_poff,
    input  logic [DW-1:0]  wr_data,
    input  logic [PPW-1:0] wr_par,
    input  word_t          peer_at_mine,
    input  pword_t         peer_par_at_mine,
    input  widx_t          peer_word,
    output word_t          own_data,
    output pword_t         own_par,
    output word_t          peer_data,
    output pword_t         peer_par
);

    word_t  mem  [WORDS];
    pword_t pmem [WORDS];

    // Start contents: rows for the loading bank, zeros elsewhere.
    initial begin
        for (int w = 0; w < WORDS; w++) begin
            mem[w]  = LOAD_ROWS ?
                      INIT_ROWS[w / WORDS_PER_ROW][(w % WORDS_PER_ROW) * WORD_W +: WORD_W] :
                      '0;
            pmem[w] = '0;
        end
    end

    // Read taps for the own port and for the other port.
    assign own_data  = mem[wr_word];
    assign own_par   = pmem[wr_word];
    assign peer_data = mem[peer_word];
    assign peer_par  = pmem[peer_word];

    // Data write: store the new lane folded with the other bank.
    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[wr_word][wr_off +: DW] <= wr_data ^ peer_at_mine[wr_off +: DW];
        end
    end

    generate
        if (PW > 0) begin : g_pwr
            // Parity write: same folding over the parity lane.
            always_ff @(posedge clk) begin
                if (wr_go) begin
                    pmem[wr_word][wr_poff +: PW] <= wr_par ^ peer_par_at_mine[wr_poff +: PW];
                end
            end
        end else begin : g_nopwr
            logic unused_pwr;

            // No parity writes at this width.
            assign unused_pwr = ^{wr_par, wr_poff, peer_par_at_mine};
        end
    endgenerate

endmodule

// File: rtl/dual_aspect_ram.sv
// Module dual_aspect_ram
// True dual-port memory of 16,384 data cells and 2,048 parity cells, each
// port at its own width. Two single-writer banks are combined by XOR so that
// every storage array has one driver, yet both ports see one cell array.
// Assumes the user never writes overlapping cells from both ports at once.
module dual_aspect_ram
    import dpm_pkg::*;
#(
    parameter int DATA_W_A = 8,
    parameter int DATA_W_B = 32,
    parameter logic [ROW_W-1:0] INIT_ROWS [ROWS] = '{default: '0},
    localparam int AW_A  = BIT_IDX_W - $clog2(DATA_W_A),
    localparam int AW_B  = BIT_IDX_W - $clog2(DATA_W_B),
    localparam int PPW_A = par_port_w(DATA_W_A),
    localparam int PPW_B = par_port_w(DATA_W_B)
) (
    input  logic                clk_a,
    input  logic                rstn_a,
    input  logic                en_a,
    input  logic                we_a,
    input  logic [AW_A-1:0]     addr_a,
    input  logic [DATA_W_A-1:0] din_a,
    input  logic [PPW_A-1:0]    pin_a,
    output logic [DATA_W_A-1:0] dout_a,
    output logic [PPW_A-1:0]    pout_a,
    input  logic                clk_b,
    input  logic                rstn_b,
    input  logic                en_b,
    input  logic                we_b,
    input  logic [AW_B-1:0]     addr_b,
    input  logic [DATA_W_B-1:0] din_b,
    input  logic [PPW_B-1:0]    pin_b,
    output logic [DATA_W_B-1:0] dout_b,
    output logic [PPW_B-1:0]    pout_b
);

    widx_t  a_word, b_word;
    off_t   a_off, b_off;
    poff_t  a_poff, b_poff;
    logic   a_go, b_go;
    word_t  a_own, b_own, a_peer, b_peer;
    pword_t a_own_p, b_own_p, a_peer_p, b_peer_p;
    word_t  a_merged, b_merged;
    pword_t a_merged_p, b_merged_p;

    // Widths outside the supported set are a configuration error.
    initial begin
        assert (width_ok(DATA_W_A) && width_ok(DATA_W_B))
            else $error("dual_aspect_ram: unsupported port width");
    end

    // Logical word seen by each port: own bank folded with the other.
    assign a_merged   = a_own ^ b_peer;
    assign a_merged_p = a_own_p ^ b_peer_p;
    assign b_merged   = b_own ^ a_peer;
    assign b_merged_p = b_own_p ^ a_peer_p;

    dpm_port #(.DW(DATA_W_A)) port_a_i (
        .clk(clk_a), .rstn(rstn_a), .en(en_a), .we(we_a), .addr(addr_a),
        .din(din_a), .pin(pin_a), .rd_data(a_merged), .rd_par(a_merged_p),
        .word_idx(a_word), .bit_off(a_off), .par_off(a_poff), .wr_go(a_go),
        .dout(dout_a), .pout(pout_a)
    );

    dpm_port #(.DW(DATA_W_B)) port_b_i (
        .clk(clk_b), .rstn(rstn_b), .en(en_b), .we(we_b), .addr(addr_b),
        .din(din_b), .pin(pin_b), .rd_data(b_merged), .rd_par(b_merged_p),
        .word_idx(b_word), .bit_off(b_off), .par_off(b_poff), .wr_go(b_go),
        .dout(dout_b), .pout(pout_b)
    );

    dpm_bank #(.DW(DATA_W_A), .LOAD_ROWS(1'b1), .INIT_ROWS(INIT_ROWS)) bank_a_i (
        .clk(clk_a), .wr_go(a_go), .wr_word(a_word), .wr_off(a_off),
        .wr_poff(a_poff), .wr_data(din_a), .wr_par(pin_a),
        .peer_at_mine(b_peer), .peer_par_at_mine(b_peer_p), .peer_word(b_word),
        .own_data(a_own), .own_par(a_own_p), .peer_data(a_peer), .peer_par(a_peer_p)
    );

    dpm_bank #(.DW(DATA_W_B), .LOAD_ROWS(1'b0), .INIT_ROWS(INIT_ROWS)) bank_b_i (
        .clk(clk_b), .wr_go(b_go), .wr_word(b_word), .wr_off(b_off),
        .wr_poff(b_poff), .wr_data(din_b), .wr_par(pin_b),
        .peer_at_mine(a_peer), .peer_par_at_mine(a_peer_p), .peer_word(a_word),
        .own_data(b_own), .own_par(b_own_p), .peer_data(b_peer), .peer_par(b_peer_p)
    );

endmodule

// File: tb/dual_aspect_ram_tb_top.sv
`timescale 1ns/1ps
module dual_aspect_ram_tb_top;

    localparam logic [255:0] TB_ROWS [64] = '{
        0:  256'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0_13579bdf_2468ace0_deadbeef_cafef00d,
        31: 256'h89abcdef_01234567_fedcba98_76543210_a5a5a5a5_5a5a5a5a_11223344_55667788,
        63: 256'h7766aa55_00ff00ff_31415926_27182818_b0b1b2b3_c0c1c2c3_d0d1d2d3_e0e1e2e3,
        default: '0
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rstn;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    // Wide configuration: 8+1 against 32+4.
    logic        en_a, we_a, pin_a, pout_a;
    logic [10:0] addr_a;
    logic [7:0]  din_a, dout_a;
    logic        en_b, we_b;
    logic [8:0]  addr_b;
    logic [31:0] din_b, dout_b;
    logic [3:0]  pin_b, pout_b;

    // Narrow configuration: 2 against 16+2.
    logic        nen_a, nwe_a, npin_a, npout_a;
    logic [12:0] naddr_a;
    logic [1:0]  ndin_a, ndout_a;
    logic        nen_b, nwe_b;
    logic [9:0]  naddr_b;
    logic [15:0] ndin_b, ndout_b;
    logic [1:0]  npin_b, npout_b;

    logic [16383:0] mdl_d, nmdl_d;
    logic [2047:0]  mdl_p, nmdl_p;

    dual_aspect_ram #(.DATA_W_A(8), .DATA_W_B(32), .INIT_ROWS(TB_ROWS)) dut_i (
        .clk_a(clk), .rstn_a(rstn), .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
        .din_a(din_a), .pin_a(pin_a), .dout_a(dout_a), .pout_a(pout_a),
        .clk_b(clk), .rstn_b(rstn), .en_b(en_b), .we_b(we_b), .addr_b(addr_b),
        .din_b(din_b), .pin_b(pin_b), .dout_b(dout_b), .pout_b(pout_b)
    );

    dual_aspect_ram #(.DATA_W_A(2), .DATA_W_B(16)) dut_nar_i (
        .clk_a(clk), .rstn_a(rstn), .en_a(nen_a), .we_a(nwe_a), .addr_a(naddr_a),
        .din_a(ndin_a), .pin_a(npin_a), .dout_a(ndout_a), .pout_a(npout_a),
        .clk_b(clk), .rstn_b(rstn), .en_b(nen_b), .we_b(nwe_b), .addr_b(naddr_b),
        .din_b(ndin_b), .pin_b(npin_b), .dout_b(ndout_b), .pout_b(npout_b)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Byte port access; checks against the model one edge later.
    task automatic a_op(input string tag, input bit w, input int adr,
                        input logic [7:0] d, input logic p);
        @(negedge clk);
        en_a = 1'b1; we_a = w; addr_a = 11'(adr); din_a = d; pin_a = p;
        @(negedge clk);
        en_a = 1'b0; we_a = 1'b0;
        if (w) begin
            mdl_d[adr*8 +: 8] = d;
            mdl_p[adr]        = p;
        end
        chk(tag, dout_a, mdl_d[adr*8 +: 8]);
        chk(tag, pout_a, mdl_p[adr]);
    endtask

    // Word port access; checks against the model one edge later.
    task automatic b_op(input string tag, input bit w, input int adr,
                        input logic [31:0] d, input logic [3:0] p);
        @(negedge clk);
        en_b = 1'b1; we_b = w; addr_b = 9'(adr); din_b = d; pin_b = p;
        @(negedge clk);
        en_b = 1'b0; we_b = 1'b0;
        if (w) begin
            mdl_d[adr*32 +: 32] = d;
            mdl_p[adr*4 +: 4]   = p;
        end
        chk(tag, dout_b, mdl_d[adr*32 +: 32]);
        chk(tag, pout_b, mdl_p[adr*4 +: 4]);
    endtask

    // R8: idle cycle with write enable and fresh data on both ports.
    task automatic idle_check();
        logic [7:0]  ha = dout_a;
        logic [31:0] hb = dout_b;
        logic        hpa = pout_a;
        logic [3:0]  hpb = pout_b;
        @(negedge clk);
        en_a = 1'b0; we_a = 1'b1; addr_a = 11'($urandom); din_a = 8'($urandom); pin_a = 1'b1;
        en_b = 1'b0; we_b = 1'b1; addr_b = 9'($urandom);  din_b = $urandom;     pin_b = 4'hf;
        @(negedge clk);
        we_a = 1'b0; we_b = 1'b0;
        chk("R8 hold a", dout_a, ha);
        chk("R8 hold b", dout_b, hb);
        chk("R8 hold pa", pout_a, hpa);
        chk("R8 hold pb", pout_b, hpb);
    endtask

    task automatic na_op(input string tag, input bit w, input int adr,
                         input logic [1:0] d, input logic p);
        @(negedge clk);
        nen_a = 1'b1; nwe_a = w; naddr_a = 13'(adr); ndin_a = d; npin_a = p;
        @(negedge clk);
        nen_a = 1'b0; nwe_a = 1'b0;
        if (w) nmdl_d[adr*2 +: 2] = d;
        chk(tag, ndout_a, nmdl_d[adr*2 +: 2]);
        chk("R4 narrow pout", npout_a, 1'b0);
    endtask

    task automatic nb_op(input string tag, input bit w, input int adr,
                         input logic [15:0] d, input logic [1:0] p);
        @(negedge clk);
        nen_b = 1'b1; nwe_b = w; naddr_b = 10'(adr); ndin_b = d; npin_b = p;
        @(negedge clk);
        nen_b = 1'b0; nwe_b = 1'b0;
        if (w) begin
            nmdl_d[adr*16 +: 16] = d;
            nmdl_p[adr*2 +: 2]   = p;
        end
        chk(tag, ndout_b, nmdl_d[adr*16 +: 16]);
        chk(tag, npout_b, nmdl_p[adr*2 +: 2]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < 64; k++) mdl_d[k*256 +: 256] = TB_ROWS[k];
        mdl_p  = '0;
        nmdl_d = '0;
        nmdl_p = '0;

        // R10: reset holds outputs at zero even with a read enabled.
        rstn = 1'b0;
        en_a = 1'b1; we_a = 1'b0; addr_a = '0; din_a = '0; pin_a = '0;
        en_b = 1'b1; we_b = 1'b0; addr_b = '0; din_b = '0; pin_b = '0;
        nen_a = 1'b0; nwe_a = 1'b0; naddr_a = '0; ndin_a = '0; npin_a = '0;
        nen_b = 1'b0; nwe_b = 1'b0; naddr_b = '0; ndin_b = '0; npin_b = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset dout_a", dout_a, 8'h00);
        chk("R10 reset dout_b", dout_b, 32'h0);
        chk("R10 reset pout_b", pout_b, 4'h0);
        en_a = 1'b0; en_b = 1'b0;
        rstn = 1'b1;

        // R5 / R6 / R1: start contents at chosen rows, including the last word.
        b_op("R5 row0", 1'b0, 0, '0, '0);
        chk("R5 row0 const", dout_b, 32'hcafef00d);
        b_op("R5 row31 low", 1'b0, 248, '0, '0);
        chk("R5 row31 const", dout_b, 32'h55667788);
        b_op("R5 row31 top", 1'b0, 255, '0, '0);
        chk("R5 row31 top const", dout_b, 32'h89abcdef);
        a_op("R5 row31 byte", 1'b0, 992, '0, '0);
        chk("R5 row31 byte const", dout_a, 8'h88);
        b_op("R6 unset row", 1'b0, 40, '0, '0);
        chk("R6 unset const", dout_b, 32'h0);
        b_op("R1 last word", 1'b0, 511, '0, '0);
        chk("R1 last word const", dout_b, 32'h7766aa55);
        a_op("R1 last byte", 1'b0, 2047, '0, '0);
        chk("R1 last byte const", dout_a, 8'h77);

        // R7: output changes only at the enabled edge.
        @(negedge clk);
        en_b = 1'b1; we_b = 1'b0; addr_b = 9'd248;
        #1;
        chk("R7 before edge", dout_b, 32'h7766aa55);
        @(negedge clk);
        en_b = 1'b0;
        chk("R7 after edge", dout_b, 32'h55667788);

        // R2 / R3: bytes in, word out, with parity order.
        a_op("R9 wr byte", 1'b1, 4, 8'h11, 1'b1);
        a_op("R9 wr byte", 1'b1, 5, 8'h22, 1'b0);
        a_op("R9 wr byte", 1'b1, 6, 8'h33, 1'b1);
        a_op("R9 wr byte", 1'b1, 7, 8'h44, 1'b1);
        b_op("R2 narrow to wide", 1'b0, 1, '0, '0);
        chk("R2 lane order", dout_b, 32'h44332211);
        chk("R3 parity order", pout_b, 4'b1101);

        // R2 / R3: word in, bytes out.
        b_op("R9 wr word", 1'b1, 2, 32'ha1b2c3d4, 4'b0110);
        a_op("R2 wide to narrow", 1'b0, 8, '0, '0);
        chk("R2 byte0", dout_a, 8'hd4);
        chk("R3 par0", pout_a, 1'b0);
        a_op("R2 wide to narrow", 1'b0, 9, '0, '0);
        chk("R3 par1", pout_a, 1'b1);
        a_op("R2 wide to narrow", 1'b0, 11, '0, '0);
        chk("R2 byte3", dout_a, 8'ha1);
        idle_check();
        b_op("R8 no idle write", 1'b0, 2, '0, '0);

        // Random mix, concentrated on a small region; R9 neighbours kept.
        for (int i = 0; i < 400; i++) begin
            bit wide = 1'($urandom);
            bit wr   = 1'($urandom);
            bool_sel: begin
                int adr;
                if (wide) begin
                    adr = (($urandom % 4) == 0) ? int'($urandom % 512) : int'($urandom % 16);
                    b_op("R2 random wide", wr, adr, $urandom, 4'($urandom));
                end else begin
                    adr = (($urandom % 4) == 0) ? int'($urandom % 2048) : int'($urandom % 64);
                    a_op("R2 random narrow", wr, adr, 8'($urandom), 1'($urandom));
                end
            end
            if ((i % 37) == 0) idle_check();
        end

        // R4: narrow port without parity; 2-bit cells against 16+2.
        na_op("R4 wr cell", 1'b1, 3, 2'b10, 1'b1);
        nb_op("R4 read wide", 1'b0, 0, '0, '0);
        chk("R2 narrow cell placement", ndout_b, 16'h0080);
        chk("R4 parity untouched", npout_b, 2'b00);
        nb_op("R3 wr word", 1'b1, 1, 16'ha5c3, 2'b11);
        na_op("R2 cell 8", 1'b0, 8, '0, '0);
        chk("R2 cell 8 const", ndout_a, 2'b11);
        na_op("R2 cell 10", 1'b0, 10, '0, '0);
        chk("R2 cell 10 const", ndout_a, 2'b00);
        na_op("R2 cell 15", 1'b0, 15, '0, '0);
        chk("R2 cell 15 const", ndout_a, 2'b10);
        na_op("R4 wr with pin", 1'b1, 9, 2'b01, 1'b1);
        nb_op("R3 parity kept", 1'b0, 1, '0, '0);
        chk("R4 parity kept const", npout_b, 2'b11);
        for (int i = 0; i < 120; i++) begin
            if (1'($urandom))
                nb_op("R2 narrow random wide", 1'($urandom), int'($urandom % 8), 16'($urandom), 2'($urandom));
            else
                na_op("R2 narrow random cell", 1'($urandom), int'($urandom % 64), 2'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule